// File: doc/BRIEF.md
# Center-Aligned PWM Timer Slice

This block is one timer slice of a pulse-width modulator. Its counter runs in one of two modes. In edge-aligned mode it counts up to the period value and then wraps to zero. In center-aligned mode it counts up to the period value and then back down to zero. The live count is compared with an active compare value. The result is a raw PWM level and a compare-match status that a downstream stage, such as an output conditioner, can consume.

Period and compare values are written into shadow registers. They reach the active registers only after a transfer request, and only at the next period boundary, so a running waveform never sees a torn update.

The slice is started by an external event line whose active edge is selectable. A detected start edge clears the counter and sets the run state in the same clock. When several slices share one global start line, they begin on the same cycle and stay phase-aligned.

Top module: `pwm_slice`

## Requirements
- R1: While `rst_n` is low, `count_o` is 0 and `running_o`, `pwm_o` and `cmp_hit_o` are all 0. After reset the slice stays idle until a start edge arrives.
- R2: With `mode_center` = 0 and the slice running, the count advances by one per clock up to the active period P. On the clock after the count equals P, it wraps to 0, so one cycle lasts P+1 clocks.
- R3: With `mode_center` = 1 and the slice running, the count rises by one per clock from 0 to P and then falls by one per clock back to 0, so one cycle lasts 2·P clocks.
- R4: A detected start edge makes the count 0 and `running_o` 1 on the next clock. This also holds while the slice is already running, and it restarts the count from zero.
- R5: `start_sel` selects the start edge of `start_in`: 2'b01 rising, 2'b10 falling, 2'b11 both, 2'b00 none. An edge that is not selected has no effect.
- R6: A write to the shadow period or compare value leaves the waveform unchanged until `shd_req` is pulsed. After a request made while the slice is running, the new values take effect at the next period boundary. In edge mode the boundary is the clock on which the count equals P; in center mode it is the clock on which the count reaches 0 while falling.
- R7: `pwm_o` is 1 exactly while the slice is running and the count is greater than or equal to the active compare value C. In center mode this sets the output on the rising slope and clears it on the falling slope, giving a symmetric pulse.
- R8: `cmp_hit_o` is 1 exactly while the slice is running and the count equals C, on either slope.
- R9: Two slices that share `start_in` and `start_sel` leave count 0 with `running_o` high on the same clock.
- R10: When a start edge and a pending transfer fall on the same period boundary, both take effect on that clock. The count restarts from 0 and then runs with the new period.
- R11: A transfer requested while the slice is idle loads the shadow values on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_center | input | 1 | 1 = up/down counting, 0 = up counting with wrap |
| start_sel | input | 2 | Start edge select (01 rise, 10 fall, 11 both, 00 none) |
| start_in | input | 1 | External start event line |
| shd_wr | input | 1 | Write `shd_period` and `shd_cmp` into the shadow registers |
| shd_period | input | W | Shadow period value |
| shd_cmp | input | W | Shadow compare value |
| shd_req | input | 1 | Request a shadow-to-active transfer |
| count_o | output | W | Current counter value |
| running_o | output | 1 | Run state |
| pwm_o | output | 1 | Raw PWM level |
| cmp_hit_o | output | 1 | Compare-match status |

## Verification
Two actions can land on the same clock: a start edge, and a shadow transfer that is due at a period boundary. The bench first arms a transfer request. It then follows its own phase model until that model marks the current cycle as the falling-slope zero in center mode, and raises the start line for exactly that edge. The result passes when the count reads 0 with the run state high on the following sample, and the next counts then trace the new, shorter triangle.

// File: rtl/pwm_slice.sv
`timescale 1ns/1ps
module pwm_slice #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_center,
  input  logic [1:0]   start_sel,
  input  logic         start_in,
  input  logic         shd_wr,
  input  logic [W-1:0] shd_period,
  input  logic [W-1:0] shd_cmp,
  input  logic         shd_req,
  output logic [W-1:0] count_o,
  output logic         running_o,
  output logic         pwm_o,
  output logic         cmp_hit_o
);

  logic [W-1:0] cnt, cnt_nx, per_act, cmp_act, per_shd, cmp_shd;
  logic run, down, down_nx, pend, start_q;
  logic start_hit, at_top, at_bottom, boundary, xfer;

  assign start_hit = (start_sel[0] & start_in & ~start_q) |
                     (start_sel[1] & ~start_in & start_q);
  assign at_top    = cnt >= per_act;
  assign at_bottom = cnt == '0;
  assign boundary  = run & (mode_center ? (down & at_bottom) : at_top);
  assign xfer      = pend & (~run | boundary);

  always_comb begin
    cnt_nx  = cnt;
    down_nx = down;
    if (start_hit) begin
      cnt_nx  = '0;
      down_nx = 1'b0;
    end else if (run) begin
      if (!mode_center) begin
        down_nx = 1'b0;
        cnt_nx  = at_top ? '0 : cnt + 1'b1;
      end else if (per_act == '0) begin
        down_nx = 1'b0;
        cnt_nx  = '0;
      end else if (!down) begin
        if (at_top) begin
          down_nx = 1'b1;
          cnt_nx  = cnt - 1'b1;
        end else begin
          cnt_nx  = cnt + 1'b1;
        end
      end else if (at_bottom) begin
        down_nx = 1'b0;
        cnt_nx  = cnt + 1'b1;
      end else begin
        cnt_nx  = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      down    <= 1'b0;
      run     <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cnt     <= cnt_nx;
      down    <= down_nx;
      start_q <= start_in;
      if (start_hit) run <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_shd <= '0;
      cmp_shd <= '0;
      per_act <= '0;
      cmp_act <= '0;
      pend    <= 1'b0;
    end else begin
      if (xfer) begin
        per_act <= per_shd;
        cmp_act <= cmp_shd;
        pend    <= 1'b0;
      end
      if (shd_req) pend <= 1'b1;
      if (shd_wr) begin
        per_shd <= shd_period;
        cmp_shd <= shd_cmp;
      end
    end
  end

  assign count_o   = cnt;
  assign running_o = run;
  assign pwm_o     = run & (cnt >= cmp_act);
  assign cmp_hit_o = run & (cnt == cmp_act);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (cnt == '0) && !run);

  p_edge_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_center && run && !at_top && !start_hit) |=> cnt == $past(cnt) + 1'b1);

  p_center_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_center && run && down && !at_bottom && !start_hit) |=> cnt == $past(cnt) - 1'b1);

  p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> (cnt == '0) && run && !down);

  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(per_act) && $stable(cmp_act));

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= per_act);

  p_hit_in_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit_o |-> pwm_o);

endmodule

// File: tb/pwm_slice_test.sv
`timescale 1ns/1ps
module pwm_slice_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic mode_center = 1'b0;
  logic [1:0] start_sel = 2'b01;
  logic start_in = 1'b0;
  logic shd_wr = 1'b0, shd_req = 1'b0;
  logic [W-1:0] shd_period = '0, shd_cmp = '0;
  logic b_wr = 1'b0, b_req = 1'b0;
  logic [W-1:0] b_period = '0, b_cmp = '0;
  logic [W-1:0] count_a, count_b;
  logic run_a, pwm_a, hit_a, run_b, pwm_b, hit_b;

  pwm_slice #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .mode_center(mode_center), .start_sel(start_sel),
    .start_in(start_in), .shd_wr(shd_wr), .shd_period(shd_period), .shd_cmp(shd_cmp),
    .shd_req(shd_req), .count_o(count_a), .running_o(run_a), .pwm_o(pwm_a), .cmp_hit_o(hit_a));

  pwm_slice #(.W(W)) uut_b (
    .clk(clk), .rst_n(rst_n), .mode_center(mode_center), .start_sel(start_sel),
    .start_in(start_in), .shd_wr(b_wr), .shd_period(b_period), .shd_cmp(b_cmp),
    .shd_req(b_req), .count_o(count_b), .running_o(run_b), .pwm_o(pwm_b), .cmp_hit_o(hit_b));

  typedef struct {
    logic [W-1:0] cnt;
    logic run, pwm, hit;
    string tag;
  } exp_t;
  exp_t expq[$];

  int vectors = 0, miscompares = 0;
  string cur_tag = "R1";
  int m_run = 0, m_n = 0, m_P = 0, m_C = 0, m_pend = 0, m_shP = 0, m_shC = 0;
  bit prev_in = 1'b0;

  function automatic int cnt_of(int n, int p, bit c);
    int pos;
    if (!c) return n % (p + 1);
    if (p == 0) return 0;
    pos = n % (2 * p);
    return (pos <= p) ? pos : 2 * p - pos;
  endfunction

  function automatic bit bnd_now();
    if (m_run == 0) return 1'b0;
    if (mode_center) return (m_P > 0) && (m_n > 0) && (m_n % (2 * m_P) == 0);
    return (m_n % (m_P + 1)) == m_P;
  endfunction

  task automatic chk(string tag, bit ok, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic tick();
    bit fire, xf;
    exp_t e;
    fire = (start_sel[0] && start_in && !prev_in) || (start_sel[1] && !start_in && prev_in);
    xf = (m_pend != 0) && (m_run == 0 || bnd_now());
    if (fire) begin
      m_n = 0;
      m_run = 1;
    end else if (m_run != 0) begin
      m_n = xf ? (mode_center ? 1 : 0) : m_n + 1;
    end
    if (xf) begin
      m_P = m_shP;
      m_C = m_shC;
      m_pend = 0;
    end
    if (shd_wr) begin
      m_shP = int'(shd_period);
      m_shC = int'(shd_cmp);
    end
    if (shd_req) m_pend = 1;
    prev_in = start_in;
    e.cnt = (m_run != 0) ? W'(cnt_of(m_n, m_P, mode_center)) : '0;
    e.run = (m_run != 0);
    e.pwm = e.run && (int'(e.cnt) >= m_C);
    e.hit = e.run && (int'(e.cnt) == m_C);
    e.tag = cur_tag;
    expq.push_back(e);
    @(negedge clk);
    shd_wr = 1'b0; shd_req = 1'b0; b_wr = 1'b0; b_req = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      vectors++;
      if (count_a !== e.cnt || run_a !== e.run || pwm_a !== e.pwm || hit_a !== e.hit) begin
        miscompares++;
        $display("FAIL %s: cnt/run/pwm/hit got %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
                 e.tag, count_a, run_a, pwm_a, hit_a, e.cnt, e.run, e.pwm, e.hit);
      end
    end
  end

  initial begin
    #800000;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count", count_a == '0, int'(count_a), 0);
    chk("R1 flags", {run_a, pwm_a, hit_a} == 3'b000, int'({run_a, pwm_a, hit_a}), 0);
    rst_n = 1'b1;

    cur_tag = "R11";
    shd_period = 5; shd_cmp = 2; shd_wr = 1'b1; shd_req = 1'b1;
    b_period = 7; b_cmp = 3; b_wr = 1'b1; b_req = 1'b1;
    repeat (3) tick();

    cur_tag = "R5";
    start_sel = 2'b00; start_in = 1'b1; repeat (3) tick();
    start_in = 1'b0; repeat (2) tick();
    chk("R5 disabled", run_a == 1'b0, int'(run_a), 0);
    start_sel = 2'b10; start_in = 1'b1; repeat (2) tick();
    chk("R5 rise ignored", run_a == 1'b0, int'(run_a), 0);
    start_in = 1'b0; tick();
    chk("R9 same start count", count_a == '0 && count_b == '0, int'(count_b), 0);
    chk("R9 same start run", run_a && run_b, int'(run_b), 1);
    cur_tag = "R2,R7,R8";
    repeat (3) tick();
    chk("R9 phase", count_a == count_b && count_b == 3, int'(count_b), 3);
    repeat (17) tick();

    cur_tag = "R6";
    shd_period = 3; shd_cmp = 1; shd_wr = 1'b1;
    repeat (10) tick();
    shd_req = 1'b1;
    repeat (15) tick();

    cur_tag = "R4";
    start_sel = 2'b01; start_in = 1'b1; repeat (5) tick();
    start_in = 1'b0; repeat (3) tick();
    start_in = 1'b1; repeat (4) tick();

    start_in = 1'b0; tick();
    cur_tag = "R3,R7,R8";
    mode_center = 1'b1; start_in = 1'b1;
    repeat (20) tick();

    cur_tag = "R6 center";
    shd_period = 4; shd_cmp = 2; shd_wr = 1'b1; shd_req = 1'b1;
    repeat (24) tick();

    cur_tag = "R10";
    start_in = 1'b0; tick();
    shd_period = 2; shd_cmp = 1; shd_wr = 1'b1; shd_req = 1'b1;
    repeat (2) tick();
    for (int i = 0; i < 40 && !bnd_now(); i++) tick();
    chk("R10 at boundary", count_a == '0 && bnd_now(), int'(count_a), 0);
    start_in = 1'b1; tick();
    chk("R10 restart", count_a == '0 && run_a, int'(count_a), 0);
    tick(); tick();
    chk("R10 new period top", count_a == 2, int'(count_a), 2);
    repeat (8) tick();

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule